// File: doc/BRIEF.md
# T1 to 2.048 MHz Receive Channel Mapper

This block sits after a T1 receive framer. The framer hands it one byte per received channel. It also marks channel 1 of each frame and gives the frame's F-bit. The block places these bytes onto a 32-slot backplane frame running at 2.048 MHz. A two-frame elastic store sits between the two sides, so the line clock and the backplane clock may drift apart. Framing and synchronisation are done upstream.

A 32-bit blank mask picks which backplane slots carry no T1 data. Blanked slots are sent as all ones. The unblanked slots take the T1 channels in ascending order. When slot 0 (the first slot) is blanked, its MSB carries the F-bit of the frame being read. The backplane side advances one slot for each `bpTick` pulse.

When the store runs dry, a whole frame is repeated. When it overflows, a whole incoming frame is deleted. Each of these controlled slips raises sticky flags. The host clears the flags by writing ones to them.

Top module: `t1_backplane_mapper`

## Requirements
- R1: After reset the blank mask is 0xFF000000 (slots 24 to 31 blanked). The three slip flags are 0 and `bpValid` is 0. With this mask, T1 channels 1 to 24 appear in slots 0 to 23 and slots 24 to 31 are 0xFF.
- R2: Each `bpTick` gives exactly one output byte, with `bpValid` high in the next cycle. `bpSlot` carries that byte's slot number. The slot number counts from 0 to 31 and then wraps to 0. Slot 0 is the backplane frame start.
- R3: A slot whose mask bit is 1 (bit n for slot n), other than slot 0, is output as 0xFF.
- R4: When mask bit 0 is 1, slot 0 is output as {F-bit, 7'b1111111}. The F-bit is the one given with channel 1 of the frame being read.
- R5: Unblanked slots take T1 channels in ascending order. With mask 0xFC010001, channels 1 to 15 go to slots 1 to 15 and channels 16 to 24 go to slots 17 to 25.
- R6: If fewer than 24 slots are unblanked, the T1 channels past the last unblanked slot are dropped. If more than 24 are unblanked, the surplus slots are output as 0xFF.
- R7: If no complete frame is waiting at a backplane frame start, the most recently read frame is output again. `slipFlag` and `slipEmpty` are set.
- R8: If a new T1 frame starts while both store buffers still hold unread frames, that incoming frame is deleted whole. `slipFlag` and `slipFull` are set.
- R9: The slip flags stay set until cleared. A `flagClr` bit of 1 clears its flag alone: bit 0 clears `slipFlag`, bit 1 clears `slipEmpty` and bit 2 clears `slipFull`.
- R10: A mask written with `cfgWrEn` takes effect at the next backplane frame start. The frame already being output keeps the old mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxValid | input | 1 | Received channel byte valid |
| rxFrameStart | input | 1 | With rxValid: this byte is T1 channel 1 |
| rxFbit | input | 1 | F-bit of the frame, sampled with rxFrameStart |
| rxByte | input | 8 | Received channel byte |
| bpTick | input | 1 | Advance the backplane by one slot |
| cfgWrEn | input | 1 | Load cfgMask into the blank mask |
| cfgMask | input | 32 | New blank mask, bit n for slot n |
| flagClr | input | 3 | Write-one-to-clear for the slip flags |
| bpValid | output | 1 | Backplane byte valid |
| bpSlot | output | 5 | Slot number of bpData |
| bpData | output | 8 | Backplane byte |
| slipFlag | output | 1 | A controlled slip has occurred |
| slipEmpty | output | 1 | A slip repeated a frame |
| slipFull | output | 1 | A slip deleted a frame |

## Verification
The bench targets slot 0 blanked with the F-bit at both 0 and 1. A mapper that ignores the F-bit, or that treats slot 0 like any other blanked slot, shows 0xFF or 0x7F in the wrong place. The bench also checks the R5 example mask, an all-zero mask and a half-blanked mask. An off-by-one in the channel counter, or one that keeps counting past channel 24, shifts or repeats bytes in those frames. A mask write in the middle of a frame catches a design that applies the new mask at once, because the tail of that frame then changes. The bench also forces both slip directions. A repeat that picks the wrong buffer outputs stale data. A deletion that overwrites a buffer still waiting to be read corrupts the next frame. Clearing the flags one at a time catches any clear that touches more than its own flag.

// File: rtl/rxmap_pkg.sv
package rxmap_pkg;
  parameter int T1_CHANS = 24;
  parameter int BP_SLOTS = 32;
  parameter int BYTE_W   = 8;
  parameter int N_BUFS   = 2;

  localparam int CH_W   = $clog2(T1_CHANS + 1);
  localparam int SLOT_W = $clog2(BP_SLOTS);
  localparam int BUF_W  = $clog2(N_BUFS);

  typedef enum logic [1:0] {SEL_ONES, SEL_FBIT, SEL_DATA} rdsel_e;

  typedef struct packed {
    logic              wrEn;
    logic [BUF_W-1:0]  wrBuf;
    logic [CH_W-1:0]   wrIdx;
    logic              wrFbitEn;
    logic              wrFbit;
    logic              rdEn;
    logic [BUF_W-1:0]  rdBuf;
    logic [CH_W-1:0]   rdIdx;
    rdsel_e            rdSel;
    logic [SLOT_W-1:0] rdSlot;
  } strobe_t;
endpackage

// File: rtl/rxmap_store.sv
module rxmap_store
  import rxmap_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [BYTE_W-1:0] wrByte,
  output logic              bpValid,
  output logic [SLOT_W-1:0] bpSlot,
  output logic [BYTE_W-1:0] bpData
);
  logic [BYTE_W-1:0] mem [N_BUFS][T1_CHANS];
  logic [N_BUFS-1:0] fbitStore;

  // Frame storage, one slice of logic per buffer
  for (genvar b = 0; b < N_BUFS; b++) begin : g_buf
    always_ff @(posedge clk) begin
      if (!rstN) begin
        fbitStore[b] <= 1'b0;
        for (int c = 0; c < T1_CHANS; c++) mem[b][c] <= '0;
      end else if (stb.wrEn && stb.wrBuf == BUF_W'(b)) begin
        mem[b][stb.wrIdx] <= wrByte;
        if (stb.wrFbitEn) fbitStore[b] <= stb.wrFbit;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bpValid <= 1'b0;
      bpSlot  <= '0;
      bpData  <= '1;
    end else begin
      bpValid <= stb.rdEn;
      if (stb.rdEn) begin
        bpSlot <= stb.rdSlot;
        case (stb.rdSel)
          SEL_FBIT: bpData <= {fbitStore[stb.rdBuf], {(BYTE_W-1){1'b1}}};
          SEL_DATA: bpData <= mem[stb.rdBuf][stb.rdIdx];
          default:  bpData <= '1;
        endcase
      end
    end
  end

  // R2: every read strobe yields a valid byte one cycle later
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    stb.rdEn |=> bpValid);
  // R3: a blank read leaves all ones on the backplane
  a_r3_blank_ones: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdEn && stb.rdSel == SEL_ONES) |=> (bpData == '1));
  // R4: the F-bit slot keeps its low bits high
  a_r4_fbit_low_ones: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdEn && stb.rdSel == SEL_FBIT) |=> (bpData[BYTE_W-2:0] == '1));
endmodule

// File: rtl/rxmap_ctrl.sv
module rxmap_ctrl
  import rxmap_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                rxValid,
  input  logic                rxFrameStart,
  input  logic                rxFbit,
  input  logic                bpTick,
  input  logic                cfgWrEn,
  input  logic [BP_SLOTS-1:0] cfgMask,
  input  logic [2:0]          flagClr,
  output strobe_t             stb,
  output logic                slipFlag,
  output logic                slipEmpty,
  output logic                slipFull
);
  localparam logic [BP_SLOTS-1:0] DEF_MASK  = {BP_SLOTS{1'b1}} << T1_CHANS;
  localparam logic [SLOT_W-1:0]   LAST_SLOT = SLOT_W'(BP_SLOTS - 1);
  localparam logic [CH_W-1:0]     LAST_CH   = CH_W'(T1_CHANS - 1);
  localparam logic [CH_W-1:0]     NUM_CH    = CH_W'(T1_CHANS);

  // write side
  logic [BUF_W-1:0]  wp;
  logic [CH_W-1:0]   wrIdx;
  logic              inFrame;
  // shared occupancy
  logic [N_BUFS-1:0] occupied, occNext;
  // read side
  logic [BUF_W-1:0]  rp, rdBufReg, curBuf;
  logic              rdOwn;
  logic [SLOT_W-1:0] slot;
  logic [CH_W-1:0]   chanIdx, curChan, chanNext;
  logic [BP_SLOTS-1:0] maskReg, maskSnap, curMask;

  logic startRx, rdStart, rdLast, freeNow, wrBusy, wrDone, setEmpty, setFull;

  always_comb begin
    startRx  = rxValid && rxFrameStart;
    rdStart  = bpTick && (slot == '0);
    rdLast   = bpTick && (slot == LAST_SLOT);
    freeNow  = rdLast && rdOwn;
    wrBusy   = occupied[wp] && !(freeNow && rdBufReg == wp);
    wrDone   = rxValid && !rxFrameStart && inFrame && (wrIdx == LAST_CH);
    setEmpty = rdStart && !occupied[rp];
    setFull  = startRx && wrBusy;

    stb = '0;
    if (startRx && !wrBusy) begin
      stb.wrEn     = 1'b1;
      stb.wrBuf    = wp;
      stb.wrIdx    = '0;
      stb.wrFbitEn = 1'b1;
      stb.wrFbit   = rxFbit;
    end else if (rxValid && !rxFrameStart && inFrame) begin
      stb.wrEn  = 1'b1;
      stb.wrBuf = wp;
      stb.wrIdx = wrIdx;
    end

    if (slot == '0) begin
      curBuf  = occupied[rp] ? rp : ~rp;
      curMask = maskReg;
      curChan = '0;
    end else begin
      curBuf  = rdBufReg;
      curMask = maskSnap;
      curChan = chanIdx;
    end
    chanNext   = curChan;
    stb.rdEn   = bpTick;
    stb.rdBuf  = curBuf;
    stb.rdSlot = slot;
    stb.rdIdx  = curChan;
    if (curMask[slot]) begin
      stb.rdSel = (slot == '0) ? SEL_FBIT : SEL_ONES;
    end else if (curChan < NUM_CH) begin
      stb.rdSel = SEL_DATA;
      chanNext  = curChan + 1'b1;
    end else begin
      stb.rdSel = SEL_ONES;
    end

    occNext = occupied;
    if (wrDone)  occNext[wp] = 1'b1;
    if (freeNow) occNext[rdBufReg] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wp        <= '0;
      wrIdx     <= '0;
      inFrame   <= 1'b0;
      occupied  <= '0;
      rp        <= '0;
      rdBufReg  <= '0;
      rdOwn     <= 1'b0;
      slot      <= '0;
      chanIdx   <= '0;
      maskReg   <= DEF_MASK;
      maskSnap  <= DEF_MASK;
      slipFlag  <= 1'b0;
      slipEmpty <= 1'b0;
      slipFull  <= 1'b0;
    end else begin
      occupied <= occNext;
      if (cfgWrEn) maskReg <= cfgMask;

      if (startRx) begin
        inFrame <= !wrBusy;
        wrIdx   <= CH_W'(1);
      end else if (rxValid && inFrame) begin
        if (wrDone) begin
          inFrame <= 1'b0;
          wp      <= ~wp;
        end else begin
          wrIdx <= wrIdx + 1'b1;
        end
      end

      if (bpTick) begin
        slot    <= (slot == LAST_SLOT) ? '0 : slot + 1'b1;
        chanIdx <= chanNext;
        if (rdStart) begin
          rdBufReg <= curBuf;
          rdOwn    <= occupied[rp];
          maskSnap <= maskReg;
        end
        if (freeNow) rp <= ~rp;
      end

      slipFlag  <= (slipFlag  & ~flagClr[0]) | setEmpty | setFull;
      slipEmpty <= (slipEmpty & ~flagClr[1]) | setEmpty;
      slipFull  <= (slipFull  & ~flagClr[2]) | setFull;
    end
  end

  // R7: a frame start with nothing waiting raises the repeat flags
  a_r7_empty_slip: assert property (@(posedge clk) disable iff (!rstN)
    (bpTick && slot == '0 && occupied == '0) |=> (slipEmpty && slipFlag));
  // R8: a frame arriving with every buffer full raises the delete flags
  a_r8_full_slip: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && rxFrameStart && occupied == '1 && !rdLast) |=> (slipFull && slipFlag));
  // R9: flags hold without a clear
  a_r9_full_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (slipFull && !flagClr[2]) |=> slipFull);
  a_r9_empty_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (slipEmpty && !flagClr[1]) |=> slipEmpty);
  // R6: channel counter never runs past the last T1 channel
  a_r6_chan_bound: assert property (@(posedge clk) disable iff (!rstN)
    chanIdx <= NUM_CH);
  // R2: the slot number advances by one on each tick
  a_r2_slot_step: assert property (@(posedge clk) disable iff (!rstN)
    (bpTick && slot != LAST_SLOT) |=> (slot == $past(slot) + 1'b1));
endmodule

// File: rtl/t1_backplane_mapper.sv
module t1_backplane_mapper
  import rxmap_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        rxValid,
  input  logic                        rxFrameStart,
  input  logic                        rxFbit,
  input  logic [rxmap_pkg::BYTE_W-1:0]   rxByte,
  input  logic                        bpTick,
  input  logic                        cfgWrEn,
  input  logic [rxmap_pkg::BP_SLOTS-1:0] cfgMask,
  input  logic [2:0]                  flagClr,
  output logic                        bpValid,
  output logic [rxmap_pkg::SLOT_W-1:0]   bpSlot,
  output logic [rxmap_pkg::BYTE_W-1:0]   bpData,
  output logic                        slipFlag,
  output logic                        slipEmpty,
  output logic                        slipFull
);
  strobe_t stb;

  rxmap_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxFrameStart(rxFrameStart),
    .rxFbit(rxFbit), .bpTick(bpTick), .cfgWrEn(cfgWrEn), .cfgMask(cfgMask),
    .flagClr(flagClr), .stb(stb), .slipFlag(slipFlag), .slipEmpty(slipEmpty),
    .slipFull(slipFull)
  );

  rxmap_store u_store (
    .clk(clk), .rstN(rstN), .stb(stb), .wrByte(rxByte),
    .bpValid(bpValid), .bpSlot(bpSlot), .bpData(bpData)
  );
endmodule

// File: tb/sim_t1_backplane_mapper.sv
module sim_t1_backplane_mapper;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rxValid = 1'b0, rxFrameStart = 1'b0, rxFbit = 1'b0;
  logic [7:0]  rxByte = '0;
  logic        bpTick = 1'b0, cfgWrEn = 1'b0;
  logic [31:0] cfgMask = '0;
  logic [2:0]  flagClr = '0;
  logic        bpValid, slipFlag, slipEmpty, slipFull;
  logic [4:0]  bpSlot;
  logic [7:0]  bpData;

  int nChecks = 0, nFails = 0;
  bit done = 1'b0;
  string curReq = "R1";
  logic [31:0] benchMask = 32'hFF00_0000;
  logic [12:0] expQ [$];

  always #10 clk = ~clk;

  t1_backplane_mapper u0 (.*);

  function automatic logic [7:0] gen(int seed, int ch);
    return 8'((seed * 29) + (ch * 7) + 3);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected slot bytes
  always @(negedge clk) begin
    if (rstN && bpValid && !done) begin
      if (expQ.size() == 0) begin
        check({curReq, " unexpected byte"}, {24'd0, bpData}, 32'hDEAD);
      end else begin
        logic [12:0] e;
        e = expQ.pop_front();
        check({curReq, " slot"}, {27'd0, bpSlot}, {27'd0, e[12:8]});
        check({curReq, " data"}, {24'd0, bpData}, {24'd0, e[7:0]});
      end
    end
  end

  task automatic writeFrame(int seed, bit f);
    for (int ch = 0; ch < 24; ch++) begin
      @(negedge clk);
      rxValid = 1'b1; rxFrameStart = (ch == 0); rxFbit = f; rxByte = gen(seed, ch);
    end
    @(negedge clk);
    rxValid = 1'b0; rxFrameStart = 1'b0;
  endtask

  task automatic setMask(logic [31:0] m);
    @(negedge clk); cfgWrEn = 1'b1; cfgMask = m;
    @(negedge clk); cfgWrEn = 1'b0;
    benchMask = m;
  endtask

  task automatic clearFlags(logic [2:0] c);
    @(negedge clk); flagClr = c;
    @(negedge clk); flagClr = '0;
  endtask

  // driver: pushes expected frame, then ticks; optional mid-frame mask write (R10)
  task automatic readFrame(int seed, bit f, string req, bit midWr, logic [31:0] newMask);
    int ch = 0;
    curReq = req;
    for (int s = 0; s < 32; s++) begin
      logic [7:0] b;
      if (benchMask[s]) b = (s == 0) ? {f, 7'h7F} : 8'hFF;
      else if (ch < 24) begin b = gen(seed, ch); ch++; end
      else b = 8'hFF;
      expQ.push_back({5'(s), b});
    end
    for (int s = 0; s < 32; s++) begin
      @(negedge clk);
      bpTick = 1'b1;
      cfgWrEn = (midWr && s == 10);
      cfgMask = newMask;
    end
    @(negedge clk);
    bpTick = 1'b0; cfgWrEn = 1'b0;
    if (midWr) benchMask = newMask;
    repeat (3) @(negedge clk);
    check({req, " queue drained"}, expQ.size(), 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    check("R1 bpValid", {31'd0, bpValid}, 0);
    check("R1 flags", {29'd0, slipFlag, slipEmpty, slipFull}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 flags after reset", {29'd0, slipFlag, slipEmpty, slipFull}, 0);

    // R1 R2: default mask, channels 1..24 in slots 0..23
    writeFrame(1, 1'b1);
    readFrame(1, 1'b1, "R1", 1'b0, '0);

    // R5 R4: example mask with F-bit 0, then F-bit 1
    setMask(32'hFC01_0001);
    writeFrame(2, 1'b0);
    readFrame(2, 1'b0, "R5", 1'b0, '0);
    writeFrame(3, 1'b1);
    readFrame(3, 1'b1, "R4", 1'b0, '0);
    check("R3 no slip in steady flow", {29'd0, slipFlag, slipEmpty, slipFull}, 0);

    // R6: surplus slots, then dropped channels; R10: mid-frame mask write
    setMask(32'h0000_0000);
    writeFrame(4, 1'b0);
    readFrame(4, 1'b0, "R6", 1'b0, '0);
    setMask(32'h0000_FFFF);
    writeFrame(5, 1'b1);
    readFrame(5, 1'b1, "R10", 1'b1, 32'hFF00_0000);

    // R7: no frame waiting, last frame repeated with new mask
    readFrame(5, 1'b1, "R7", 1'b0, '0);
    check("R7 slipFlag", {31'd0, slipFlag}, 1);
    check("R7 slipEmpty", {31'd0, slipEmpty}, 1);
    check("R7 slipFull", {31'd0, slipFull}, 0);

    // R9: clear only the empty flag
    clearFlags(3'b010);
    check("R9 slipFlag kept", {31'd0, slipFlag}, 1);
    check("R9 slipEmpty cleared", {31'd0, slipEmpty}, 0);
    clearFlags(3'b001);
    check("R9 slipFlag cleared", {31'd0, slipFlag}, 0);

    // R8: third frame deleted while both buffers full
    writeFrame(6, 1'b0);
    writeFrame(7, 1'b1);
    writeFrame(8, 1'b0);
    check("R8 slipFull", {31'd0, slipFull}, 1);
    check("R8 slipFlag", {31'd0, slipFlag}, 1);
    readFrame(6, 1'b0, "R8", 1'b0, '0);
    readFrame(7, 1'b1, "R8", 1'b0, '0);
    check("R9 full sticky", {31'd0, slipFull}, 1);
    check("R8 no empty slip", {31'd0, slipEmpty}, 0);
    clearFlags(3'b111);
    check("R9 all cleared", {29'd0, slipFlag, slipEmpty, slipFull}, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nChecks++; nFails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule